// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Slave

This block is a byte-oriented slave on a two-wire serial bus (SCL clock, SDA data). It holds a small bank of 8-bit configuration registers whose contents drive a flat parallel output bus into the rest of the chip. SCL and SDA arrive already synchronised to the fast system clock. The block finds start and stop conditions in them, answers only to the 7-bit device address 7'h69, and takes the first byte after a write-direction address as the register pointer.

Each later byte of a write frame lands at the pointer, and the pointer then advances by one. A repeated start with the read direction streams registers out, beginning at the pointer, until the master withholds its acknowledge. The 8-bit pointer wraps from FFh to 00h. Only eleven addresses hold storage. Every other address accepts writes and acknowledges them, throws the data away, and reads back as zero.

The SDA output is a pull-low request (`sda_pull_o`). The pad logic outside this block turns it into an open-drain driver.

Top module: `twi_cfg_slave`

## Requirements
- R1: After reset every register and the whole `cfg_o` bus read as zero, and `sda_pull_o` is 0 (SDA released).
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The slave acknowledges an address byte only when its upper seven bits equal 7'h69; bit 0 is the direction (0 = write, 1 = read). On any other address it gives no acknowledge, and it ignores all bytes until the next start or stop.
- R3: After the address byte, the pointer byte and every write data byte, the slave pulls SDA low through the whole of the ninth SCL clock. In write frames it releases SDA after that clock's falling edge.
- R4: In a write frame the first byte after the address sets the pointer. Each following byte is stored at the pointer, and the pointer then advances by one.
- R5: The pointer advances modulo 256, so a write or read burst that passes FFh goes on at 00h.
- R6: `sda_pull_o` changes only while SCL is low.
- R7: Storage exists only at 09h, 0Ch, 12h, 13h, 40h, 41h, 42h, 44h, 45h, 46h and 47h. These appear on `cfg_o` in that order, address 09h in bits [7:0] and each next one 8 bits higher. Writes to any other address are acknowledged but change nothing.
- R8: After a read-direction address is acknowledged, the slave sends bytes MSB first, one bit per SCL clock, starting at the pointer and advancing it after each byte. Addresses without storage return 00h.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released over any further SCL clocks until the next start or stop.
- R10: The pointer is kept across stop and start conditions, so a frame that carries only a pointer sets where the next read begins, and a new read frame goes on where the last one stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| sda_pull_o | output | 1 | 1 requests SDA to be driven low |
| cfg_o | output | 88 | Register contents, eleven bytes in the R7 order |

## Verification
A bit counter or frame state that has drifted shows up first on SDA. Within one byte time the acknowledge lands on the wrong SCL clock or vanishes, or a read byte comes out shifted, so every byte of the full 256-address write and read sweeps shows the fault in the very next ninth clock. A wrong pointer step or a broken wrap moves write data into the wrong `cfg_o` byte and changes read data, and this is visible at the end of the burst that crosses the boundary. A reserved address that is shielded wrongly either changes `cfg_o` on that write or returns a non-zero byte on that read.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PTR_W     = 8;
  localparam int unsigned NUM_SLOTS = 11;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned CNT_W     = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_PTR,
    RX_DATA
  } rx_kind_e;

  // Returns {implemented, slot index}; slot order sets the cfg_o layout.
  function automatic logic [SLOT_W:0] slot_of(input logic [PTR_W-1:0] a);
    logic [SLOT_W:0] r;
    case (a)
      8'h09:   r = {1'b1, SLOT_W'(0)};
      8'h0C:   r = {1'b1, SLOT_W'(1)};
      8'h12:   r = {1'b1, SLOT_W'(2)};
      8'h13:   r = {1'b1, SLOT_W'(3)};
      8'h40:   r = {1'b1, SLOT_W'(4)};
      8'h41:   r = {1'b1, SLOT_W'(5)};
      8'h42:   r = {1'b1, SLOT_W'(6)};
      8'h44:   r = {1'b1, SLOT_W'(7)};
      8'h45:   r = {1'b1, SLOT_W'(8)};
      8'h46:   r = {1'b1, SLOT_W'(9)};
      8'h47:   r = {1'b1, SLOT_W'(10)};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                     input logic [6:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twi_frame_engine.sv
module twi_frame_engine
  import twi_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  bus_state_e        st_q;
  rx_kind_e          kind_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q;
  logic              pull_q;
  logic              mack_q;

  // Named internal events
  logic byte_done;
  logic dev_hit;
  logic ack_end;
  logic tx_load;
  logic mack_end;

  assign byte_done = (st_q == ST_RX) && scl_fall_i && (bitcnt_q == FULL_CNT);
  assign dev_hit   = byte_done && (kind_q == RX_DEV) && dev_match(sr_q, DEV_ADDR);
  assign ack_end   = (st_q == ST_ACK) && scl_fall_i;
  assign mack_end  = (st_q == ST_MACK) && scl_fall_i;
  assign tx_load   = (ack_end && (kind_q == RX_DEV) && rw_q) || (mack_end && mack_q);
  assign wr_en_o   = byte_done && (kind_q == RX_DATA);

  assign reg_addr_o = ptr_q;
  assign wr_data_o  = sr_q;
  assign sda_pull_o = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= RX_DEV;
      bitcnt_q <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_RX;
      kind_q   <= RX_DEV;
      bitcnt_q <= '0;
      pull_q   <= 1'b0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      pull_q   <= 1'b0;
    end else if (tx_load) begin
      st_q     <= ST_TX;
      bitcnt_q <= '0;
      tx_q     <= rd_data_i;
      pull_q   <= ~rd_data_i[BYTE_W-1];
      ptr_q    <= ptr_step(ptr_q);
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise_i && (bitcnt_q < FULL_CNT)) begin
            sr_q     <= {sr_q[BYTE_W-2:0], sda_i};
            bitcnt_q <= bitcnt_q + CNT_W'(1);
          end else if (byte_done) begin
            case (kind_q)
              RX_DEV: begin
                if (dev_hit) begin
                  rw_q   <= sr_q[0];
                  st_q   <= ST_ACK;
                  pull_q <= 1'b1;
                end else begin
                  st_q   <= ST_WAIT;
                end
              end
              RX_PTR: begin
                ptr_q  <= sr_q;
                st_q   <= ST_ACK;
                pull_q <= 1'b1;
              end
              default: begin
                ptr_q  <= ptr_step(ptr_q);
                st_q   <= ST_ACK;
                pull_q <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ack_end) begin
            pull_q   <= 1'b0;
            bitcnt_q <= '0;
            st_q     <= ST_RX;
            kind_q   <= (kind_q == RX_DEV) ? RX_PTR : RX_DATA;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bitcnt_q == LAST_BIT) begin
              pull_q <= 1'b0;
              mack_q <= 1'b0;
              st_q   <= ST_MACK;
            end else begin
              bitcnt_q <= bitcnt_q + CNT_W'(1);
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              pull_q   <= ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (mack_end) begin
            st_q <= ST_WAIT;
          end
        end
        default: begin
        end
      endcase
    end
  end

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q != $past(pull_q)) |-> !scl_i); // R6

  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ACK) && scl_i) |-> pull_q); // R3

  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !pull_q); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (ptr_q == $past(ptr_q) + 8'd1)); // R5

endmodule

// File: rtl/twi_cfg_bank.sv
module twi_cfg_bank
  import twi_cfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [PTR_W-1:0]            addr_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  output logic [BYTE_W-1:0]           rd_data_o,
  output logic [NUM_SLOTS*BYTE_W-1:0] cfg_flat_o
);

  logic [SLOT_W:0]                       hit;
  logic                                  addr_impl;
  logic [SLOT_W-1:0]                     slot;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0]      regs_w;

  assign hit       = slot_of(addr_i);
  assign addr_impl = hit[SLOT_W];
  assign slot      = hit[SLOT_W-1:0];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic              sel;
    logic [BYTE_W-1:0] q;
    assign sel = wr_en_i && addr_impl && (slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= wr_data_i;
    end
    assign regs_w[g] = q;
    assign cfg_flat_o[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (addr_impl && (slot == SLOT_W'(k))) rd_data_o = regs_w[k];
    end
  end

  AST_RSV_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !addr_impl) |=> $stable(cfg_flat_o)); // R7

endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
  import twi_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_pull_o,
  output logic [NUM_SLOTS*BYTE_W-1:0] cfg_o
);

  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic              wr_en;
  logic [PTR_W-1:0]  reg_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;

  twi_line_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  twi_frame_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_ev),
    .stop_i    (stop_ev),
    .rd_data_i (rd_data),
    .sda_pull_o(sda_pull_o),
    .wr_en_o   (wr_en),
    .reg_addr_o(reg_addr),
    .wr_data_o (wr_data)
  );

  twi_cfg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (reg_addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .cfg_flat_o(cfg_o)
  );

  AST_NO_PULL_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o); // R9

endmodule

// File: tb/twi_cfg_slave_tb.sv
`timescale 1ns/1ps
module twi_cfg_slave_tb;

  localparam int Q = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_pull_o;
  logic [87:0] cfg_o;
  wire         sda_line = m_sda & ~sda_pull_o;

  int n_checks = 0;
  int n_fail = 0;
  int r6_bad = 0;
  logic pull_prev = 1'b0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  twi_cfg_slave #(.DEV_ADDR(7'h69)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .cfg_o(cfg_o)
  );

  always @(negedge clk) begin
    if (rst_n && (sda_pull_o != pull_prev) && scl) r6_bad++;
    pull_prev = sda_pull_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit has_store(input logic [7:0] a);
    return (a == 8'h09) || (a == 8'h0C) || (a == 8'h12) || (a == 8'h13) ||
           ((a[7:3] == 5'b01000) && (a != 8'h43));
  endfunction

  function automatic logic [7:0] slot_addr(input int k);
    logic [7:0] tbl [11] = '{8'h09, 8'h0C, 8'h12, 8'h13, 8'h40, 8'h41,
                             8'h42, 8'h44, 8'h45, 8'h46, 8'h47};
    return tbl[k];
  endfunction

  function automatic logic [87:0] exp_flat();
    logic [87:0] f;
    for (int k = 0; k < 11; k++) f[k*8 +: 8] = model[slot_addr(k)];
    return f;
  endfunction

  function automatic logic [7:0] wd(input logic [7:0] a, input logic [7:0] salt);
    return a * 8'd29 + salt;
  endfunction

  function automatic logic [7:0] rd_exp(input logic [7:0] a);
    return has_store(a) ? model[a] : 8'h00;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    a1 = ~sda_line; tick(Q);
    a2 = ~sda_line;
    scl = 1'b0;   tick(Q);
    acked = a1 & a2;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      b[i] = sda_line; tick(Q);
      scl = 1'b0;   tick(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(1);
    m_sda = 1'b1; tick(Q-1);
  endtask

  initial begin
    bit ack;
    logic [7:0] got;
    int nack_cnt;
    int rel_bad;
    int hi_bad;
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    tick(8);
    rst_n = 1'b1;
    tick(4);

    check(cfg_o == '0, "R1 cfg reset", cfg_o, 0);
    check(sda_pull_o == 1'b0, "R1 sda released", sda_pull_o, 0);

    // R2: foreign addresses get no acknowledge and no effect
    bus_start();
    send_byte(8'hD0, ack); check(!ack, "R2 addr 68h nack", ack, 0);
    send_byte(8'h09, ack); check(!ack, "R2 ignored byte", ack, 0);
    send_byte(8'hA5, ack); check(!ack, "R2 ignored byte", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h93, ack); check(!ack, "R2 addr 49h nack", ack, 0);
    bus_stop();
    check(cfg_o == '0, "R2 cfg untouched", cfg_o, 0);

    // R4 R7: write sweep over all 256 addresses
    bus_start();
    send_byte(8'hD2, ack); check(ack, "R2 addr 69h ack", ack, 1);
    send_byte(8'h00, ack); check(ack, "R3 pointer ack", ack, 1);
    nack_cnt = 0; rel_bad = 0;
    for (int a = 0; a < 256; a++) begin
      got = wd(8'(a), 8'h11);
      send_byte(got, ack);
      if (!ack) nack_cnt++;
      if (sda_pull_o) rel_bad++;
      if (has_store(8'(a))) model[a] = got;
    end
    bus_stop();
    check(nack_cnt == 0, "R3/R7 every data byte acked", nack_cnt, 0);
    check(rel_bad == 0, "R3 release after ack", rel_bad, 0);
    for (int k = 0; k < 11; k++)
      check(cfg_o[k*8 +: 8] == model[slot_addr(k)], "R4/R7 slot value",
            cfg_o[k*8 +: 8], model[slot_addr(k)]);

    // R8: read sweep over all 256 addresses
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte(8'hD3, ack); check(ack, "R2 read addr ack", ack, 1);
    for (int a = 0; a < 256; a++) begin
      recv_byte(a != 255, got);
      check(got == rd_exp(8'(a)), "R8 read byte", got, rd_exp(8'(a)));
    end
    hi_bad = 0;
    repeat (9) begin
      tick(Q); scl = 1'b1; tick(Q);
      if (!sda_line) hi_bad++;
      tick(Q); scl = 1'b0; tick(Q);
    end
    check(hi_bad == 0, "R9 released after nack", hi_bad, 0);
    bus_stop();

    // R5: write burst wraps FFh -> 00h and lands at 09h
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hFF, ack);
    for (int i = 0; i < 11; i++) begin
      got = wd(8'(8'hFF + i), 8'h77);
      send_byte(got, ack);
      if (has_store(8'(8'hFF + i))) model[8'(8'hFF + i)] = got;
    end
    bus_stop();
    check(cfg_o[7:0] == wd(8'h09, 8'h77), "R5 wrap write", cfg_o[7:0], wd(8'h09, 8'h77));
    check(cfg_o == exp_flat(), "R5 cfg after wrap", cfg_o, exp_flat());

    // R5 R8: read burst wraps
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hD3, ack);
    for (int i = 0; i < 12; i++) begin
      recv_byte(i != 11, got);
      check(got == rd_exp(8'(8'hFE + i)), "R5 wrap read", got, rd_exp(8'(8'hFE + i)));
    end
    bus_stop();

    // R10: pointer-only frame, then reads continue across frames
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h44, ack);
    bus_stop();
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b1, got); check(got == model[8'h44], "R10 read at 44h", got, model[8'h44]);
    recv_byte(1'b0, got); check(got == model[8'h45], "R10 read at 45h", got, model[8'h45]);
    bus_stop();
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b0, got); check(got == model[8'h46], "R10 continue at 46h", got, model[8'h46]);
    bus_stop();

    check(r6_bad == 0, "R6 sda change only with scl low", r6_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule